// File: doc/BRIEF.md
# Multi-Scheme Load Modulation Encoder

This block turns a serial stream of data bits into the on/off control for a transponder's damping load. A bit-period generator, clocked by a field-clock enable, sets the bit rate. The rate comes either from a binary formula or from an eight-entry table of legacy rates. The generator raises a strobe during the last field clock of each bit, so that the source can present the next bit in time. The bit is captured at the boundary and can first be inverted. It is then coded in one of eleven schemes: direct/NRZ, Manchester, two bi-phase variants, four FSK subcarrier pairings and three PSK phase rules.

The encoder sits between a memory sequencer, which supplies one bit per strobe, and the analog load switch. The rate and coding inputs are set up while reset is asserted and held still afterwards. No output is registered, so the drive follows the encoder state directly.

Top module: `lmod_encoder`

## Requirements
- R1: All internal state advances only on clock edges where `fc_en` is 1, so `mod_out` is unchanged on the cycle after one where `fc_en` is 0.
- R2: With `ext_mode` = 1, a bit lasts 2·`rate_n`+2 enabled field clocks.
- R3: With `ext_mode` = 0, a bit lasts 8, 16, 32, 40, 50, 64, 100 or 128 enabled field clocks for `rate_code` = 0 to 7 respectively.
- R4: `bit_strobe` is 1 only when `fc_en` is 1 and the current field clock is the last of a bit. The value of `bit_in` at that edge becomes the data bit for the whole of the next bit.
- R5: With `coding` = 0 (NRZ), `mod_out` equals the current data bit for the entire bit.
- R6: With `coding` = 1 (Manchester), `mod_out` is the inverse of the data bit for the first P/2 field clocks of a bit (P = bit period) and equals the bit for the rest. A 0 therefore falls at mid-bit and a 1 rises.
- R7: With `coding` = 2 or 3 (bi-phase), the level inverts at every bit boundary. It also inverts at mid-bit (field clock P/2) when the bit is 1 for code 2, or 0 for code 3.
- R8: With `coding` = 4/5/6/7 (FSK), the subcarrier period in field clocks is, for a data bit of 0 and 1 respectively: 5 and 8 (code 4), 10 and 8 (code 5), 8 and 5 (code 6), 8 and 10 (code 7). The subcarrier is high for the first floor(D/2) clocks of each period D and restarts at every bit boundary.
- R9: With `coding` = 8/9/10 (PSK), the carrier period is 2, 4 or 8 field clocks for `psk_sel` = 0, 1, 2 (3 behaves as 2). The carrier is high in the first half of its period, aligned to the bit start, and `mod_out` is the carrier XOR a phase flag.
- R10: The PSK phase flag toggles at a bit boundary when the incoming bit differs from the outgoing one (code 8), when the incoming bit is 1 (code 9), or when the outgoing bit is 0 and the incoming bit is 1 (code 10).
- R11: With `inv_en` = 1, the captured data bit is the complement of `bit_in`, and every coding operates on that complement.
- R12: Coding values 11 to 15 hold `mod_out` at 0.
- R13: Reset clears the bit phase, the data bit, the bi-phase level and the PSK phase flag. The first bit after reset is therefore a 0 at phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_en | input | 1 | Field-clock enable; one pulse per field clock |
| bit_in | input | 1 | Next data bit, captured at the bit boundary |
| inv_en | input | 1 | Invert data before coding |
| ext_mode | input | 1 | 1: binary rate formula, 0: legacy rate table |
| rate_n | input | NW (6) | Binary rate field n, period 2n+2 |
| rate_code | input | 3 | Legacy rate selector |
| coding | input | 4 | Coding scheme select |
| psk_sel | input | 2 | PSK carrier select |
| mod_out | output | 1 | Damping drive, 1 = load on |
| bit_strobe | output | 1 | Last field clock of the current bit |

## Verification
A wrong bit-phase count shows at once as `bit_strobe` pulsing on the wrong field clock, and it shifts every Manchester and bi-phase mid-bit edge within the same bit. Stale bi-phase level or PSK phase state is invisible until the next boundary. It then appears as a missing boundary transition or as a carrier of the wrong polarity for the whole following bit. A wrong FSK divisor shows within one subcarrier period of the bit start. The reference model is compared on every cycle, so each such fault is caught in the first clock where the drive differs.

// File: rtl/lmod_pkg.sv
package lmod_pkg;

  typedef enum logic [3:0] {
    CODE_NRZ        = 4'd0,
    CODE_MANCH      = 4'd1,
    CODE_BIPH_ONE   = 4'd2,
    CODE_BIPH_ZERO  = 4'd3,
    CODE_FSK_A      = 4'd4,
    CODE_FSK_B      = 4'd5,
    CODE_FSK_A_SWAP = 4'd6,
    CODE_FSK_B_SWAP = 4'd7,
    CODE_PSK_CHG    = 4'd8,
    CODE_PSK_ONE    = 4'd9,
    CODE_PSK_RISE   = 4'd10
  } coding_e;

  // Legacy bit period in field clocks
  function automatic logic [7:0] legacy_period(input logic [2:0] code);
    logic [7:0] p;
    case (code)
      3'd0:    p = 8'd8;
      3'd1:    p = 8'd16;
      3'd2:    p = 8'd32;
      3'd3:    p = 8'd40;
      3'd4:    p = 8'd50;
      3'd5:    p = 8'd64;
      3'd6:    p = 8'd100;
      default: p = 8'd128;
    endcase
    return p;
  endfunction

  // FSK subcarrier period for the active data bit
  function automatic logic [3:0] fsk_divisor(input logic [3:0] code, input logic b);
    logic [3:0] d;
    case (code)
      CODE_FSK_A:      d = b ? 4'd8  : 4'd5;
      CODE_FSK_B:      d = b ? 4'd8  : 4'd10;
      CODE_FSK_A_SWAP: d = b ? 4'd5  : 4'd8;
      CODE_FSK_B_SWAP: d = b ? 4'd10 : 4'd8;
      default:         d = 4'd8;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lmod_rate_gen.sv
module lmod_rate_gen #(
  parameter int NW = 6,
  parameter int PW = NW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_en,
  input  logic          ext_mode,
  input  logic [NW-1:0] rate_n,
  input  logic [2:0]    rate_code,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] half,
  output logic          last
);
  import lmod_pkg::*;

  logic [PW-1:0] period;
  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    if (ext_mode) period = (PW'(rate_n) << 1) + PW'(2);
    else          period = PW'(legacy_period(rate_code));
  end

  assign last  = (ph_q == period - PW'(1));
  assign half  = period >> 1;
  assign phase = ph_q;

  always_comb begin
    ph_d = ph_q;
    if (fc_en) begin
      if (last) ph_d = '0;
      else      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/lmod_fsk_gen.sv
module lmod_fsk_gen #(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fc_en,
  input  logic       restart,
  input  logic [3:0] coding,
  input  logic       cur_bit,
  output logic       wave
);
  import lmod_pkg::*;

  logic [CW-1:0] div;
  logic [CW-1:0] sc_q, sc_d;

  assign div  = CW'(fsk_divisor(coding, cur_bit));
  assign wave = (sc_q < (div >> 1));

  always_comb begin
    sc_d = sc_q;
    if (fc_en) begin
      if (restart || (sc_q == div - CW'(1))) sc_d = '0;
      else                                   sc_d = sc_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= sc_d;
  end

endmodule

// File: rtl/lmod_psk_gen.sv
module lmod_psk_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fc_en,
  input  logic       advance,
  input  logic [3:0] coding,
  input  logic [1:0] psk_sel,
  input  logic [2:0] phase_lo,
  input  logic       cur_bit,
  input  logic       next_bit,
  output logic       wave
);
  import lmod_pkg::*;

  logic flip_q, flip_d;
  logic toggle;
  logic carrier;

  always_comb begin
    case (coding)
      CODE_PSK_CHG:  toggle = cur_bit ^ next_bit;
      CODE_PSK_ONE:  toggle = next_bit;
      CODE_PSK_RISE: toggle = ~cur_bit & next_bit;
      default:       toggle = 1'b0;
    endcase
  end

  always_comb begin
    case (psk_sel)
      2'd0:    carrier = ~phase_lo[0];
      2'd1:    carrier = ~phase_lo[1];
      default: carrier = ~phase_lo[2];
    endcase
  end

  assign wave = carrier ^ flip_q;

  always_comb begin
    flip_d = flip_q;
    if (fc_en && advance && toggle) flip_d = ~flip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flip_q <= 1'b0;
    else        flip_q <= flip_d;
  end

endmodule

// File: rtl/lmod_encoder.sv
module lmod_encoder #(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_en,
  input  logic          bit_in,
  input  logic          inv_en,
  input  logic          ext_mode,
  input  logic [NW-1:0] rate_n,
  input  logic [2:0]    rate_code,
  input  logic [3:0]    coding,
  input  logic [1:0]    psk_sel,
  output logic          mod_out,
  output logic          bit_strobe
);
  import lmod_pkg::*;

  localparam int PW = NW + 2;

  logic [PW-1:0] phase, half;
  logic          last;
  logic          boundary;
  logic          next_bit;
  logic          cur_q, cur_d;
  logic          lvl_q, lvl_d;
  logic          mark;
  logic          second_half;
  logic          fsk_wave, psk_wave;

  lmod_rate_gen #(.NW(NW), .PW(PW)) u_rate (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .ext_mode(ext_mode),
    .rate_n(rate_n), .rate_code(rate_code),
    .phase(phase), .half(half), .last(last)
  );

  assign boundary    = fc_en & last;
  assign bit_strobe  = boundary;
  assign next_bit    = bit_in ^ inv_en;
  assign second_half = (phase >= half);
  assign mark        = (coding == CODE_BIPH_ONE) ? cur_q : ~cur_q;

  lmod_fsk_gen #(.CW(4)) u_fsk (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .restart(boundary),
    .coding(coding), .cur_bit(cur_q), .wave(fsk_wave)
  );

  lmod_psk_gen u_psk (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .advance(boundary),
    .coding(coding), .psk_sel(psk_sel), .phase_lo(phase[2:0]),
    .cur_bit(cur_q), .next_bit(next_bit), .wave(psk_wave)
  );

  always_comb begin
    cur_d = cur_q;
    lvl_d = lvl_q;
    if (boundary) begin
      cur_d = next_bit;
      lvl_d = ~(lvl_q ^ mark);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      lvl_q <= lvl_d;
    end
  end

  always_comb begin
    case (coding)
      CODE_NRZ:        mod_out = cur_q;
      CODE_MANCH:      mod_out = second_half ? cur_q : ~cur_q;
      CODE_BIPH_ONE,
      CODE_BIPH_ZERO:  mod_out = lvl_q ^ (second_half & mark);
      CODE_FSK_A,
      CODE_FSK_B,
      CODE_FSK_A_SWAP,
      CODE_FSK_B_SWAP: mod_out = fsk_wave;
      CODE_PSK_CHG,
      CODE_PSK_ONE,
      CODE_PSK_RISE:   mod_out = psk_wave;
      default:         mod_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/lmod_encoder_chk.sv
module lmod_encoder_chk #(
  parameter int NW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fc_en,
  input logic          ext_mode,
  input logic [NW-1:0] rate_n,
  input logic [3:0]    coding,
  input logic          mod_out,
  input logic          bit_strobe
);
  localparam int GW = NW + 2;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gap_q <= '0;
    else if (fc_en) gap_q <= bit_strobe ? '0 : gap_q + GW'(1);
  end

  assert_strobe_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> fc_en);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> $stable(mod_out));

  assert_nrz_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (coding == 4'd0) && !bit_strobe |=> $stable(mod_out));

  assert_biphase_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((coding == 4'd2) || (coding == 4'd3)) && bit_strobe |=> (mod_out != $past(mod_out)));

  assert_ext_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode && bit_strobe |-> (gap_q == ((GW'(rate_n) << 1) + GW'(1))));

  assert_period_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (gap_q >= GW'(1)) && (gap_q <= GW'(127)));

endmodule

bind lmod_encoder lmod_encoder_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .ext_mode(ext_mode),
  .rate_n(rate_n), .coding(coding), .mod_out(mod_out), .bit_strobe(bit_strobe)
);

// File: tb/tb_lmod_encoder.sv
`timescale 1ns/1ps
module tb_lmod_encoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fc_en, bit_in, inv_en, ext_mode;
  logic [5:0] rate_n;
  logic [2:0] rate_code;
  logic [3:0] coding;
  logic [1:0] psk_sel;
  logic       mod_out, bit_strobe;

  always #5 clk = ~clk;

  lmod_encoder dut (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .bit_in(bit_in), .inv_en(inv_en),
    .ext_mode(ext_mode), .rate_n(rate_n), .rate_code(rate_code), .coding(coding),
    .psk_sel(psk_sel), .mod_out(mod_out), .bit_strobe(bit_strobe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // reference model state
  logic [15:0] pat = 16'b1011_0010_0111_0100;
  int P, fcnt, nb;
  bit cur, lvl, pph;

  function automatic int period_of(bit ext, int n, int code);
    if (ext) return 2 * n + 2;
    case (code)
      0: return 8;   1: return 16;  2: return 32;  3: return 40;
      4: return 50;  5: return 64;  6: return 100; default: return 128;
    endcase
  endfunction

  function automatic int fsk_d(int c, bit b);
    case (c)
      4: return b ? 8 : 5;
      5: return b ? 8 : 10;
      6: return b ? 5 : 8;
      default: return b ? 10 : 8;
    endcase
  endfunction

  function automatic bit exp_mod();
    int h, d, s;
    bit mk;
    h = P / 2;
    mk = (coding == 4'd2) ? cur : !cur;
    case (int'(coding))
      0: return cur;
      1: return (fcnt >= h) ? cur : !cur;
      2, 3: return lvl ^ ((fcnt >= h) && mk);
      4, 5, 6, 7: begin d = fsk_d(int'(coding), cur); return (fcnt % d) < (d / 2); end
      8, 9, 10: begin
        s = (psk_sel == 2'd0) ? 2 : (psk_sel == 2'd1) ? 4 : 8;
        return ((fcnt % s) < (s / 2)) ^ pph;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %b expected %b (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  task automatic model_edge();
    bit nbit, flip, mk;
    if (!fc_en) return;
    if (fcnt == P - 1) begin
      nbit = pat[nb % 16] ^ inv_en;
      case (int'(coding))
        8:  flip = (cur != nbit);
        9:  flip = nbit;
        10: flip = !cur && nbit;
        default: flip = 1'b0;
      endcase
      if (flip) pph = !pph;
      mk  = (coding == 4'd2) ? cur : !cur;
      lvl = !(lvl ^ mk);
      cur = nbit;
      nb++;
      fcnt = 0;
    end else begin
      fcnt++;
    end
  endtask

  task automatic run_case(string tag, int c, bit ext, int n, int code, int sel,
                          bit inv, int bits, bit gated);
    @(negedge clk);
    rst_n = 1'b0; fc_en = 1'b0;
    coding = 4'(c); ext_mode = ext; rate_n = 6'(n); rate_code = 3'(code);
    psk_sel = 2'(sel); inv_en = inv;
    P = period_of(ext, n, code);
    fcnt = 0; nb = 0; cur = 0; lvl = 0; pph = 0;
    bit_in = pat[0];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R13", "reset mod_out", mod_out, exp_mod());
      check("R13", "reset strobe", bit_strobe, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    while (nb < bits && !done) begin
      @(negedge clk);
      fc_en  = gated ? ((cyc % 4) != 3) : 1'b1;
      bit_in = pat[nb % 16];
      #1;
      check(tag, "mod_out", mod_out, exp_mod());
      check("R4", "bit_strobe", bit_strobe, fc_en && (fcnt == P - 1));
      @(posedge clk);
      model_edge();
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; fc_en = 1'b0; bit_in = 1'b0; inv_en = 1'b0; ext_mode = 1'b0;
    rate_n = '0; rate_code = '0; coding = '0; psk_sel = '0;
    // legacy rate table sweep, NRZ (R3, R5)
    for (int k = 0; k < 8; k++) run_case("R3_R5", 0, 1'b0, 0, k, 0, 1'b0, 4, 1'b0);
    // binary formula, minimum and maximum period (R2), gated enable (R1)
    run_case("R2_R5", 0, 1'b1, 0, 0, 0, 1'b0, 16, 1'b1);
    run_case("R2_R5", 0, 1'b1, 63, 0, 0, 1'b0, 4, 1'b0);
    // inversion (R11)
    run_case("R11", 0, 1'b1, 3, 0, 0, 1'b1, 16, 1'b0);
    run_case("R11_R6", 1, 1'b1, 3, 0, 0, 1'b1, 16, 1'b1);
    // Manchester (R6)
    run_case("R6", 1, 1'b0, 4, 0, 0, 1'b0, 12, 1'b1);
    run_case("R6", 1, 1'b1, 0, 0, 0, 1'b0, 16, 1'b0);
    // bi-phase variants (R7)
    run_case("R7", 2, 1'b1, 7, 0, 0, 1'b0, 16, 1'b1);
    run_case("R7", 3, 1'b1, 7, 0, 0, 1'b0, 16, 1'b0);
    // FSK pairings (R8)
    for (int c = 4; c < 8; c++) run_case("R8", c, 1'b0, 0, 3, 0, 1'b0, 12, 1'b1);
    run_case("R8_R11", 5, 1'b0, 0, 3, 0, 1'b1, 8, 1'b0);
    // PSK rules and carriers (R9, R10)
    run_case("R9_R10", 8, 1'b1, 7, 0, 0, 1'b0, 16, 1'b1);
    run_case("R9_R10", 9, 1'b1, 7, 0, 1, 1'b0, 16, 1'b0);
    run_case("R9_R10", 10, 1'b1, 7, 0, 2, 1'b0, 16, 1'b1);
    run_case("R9_R10", 8, 1'b1, 11, 0, 3, 1'b1, 12, 1'b0);
    // undefined coding (R12)
    run_case("R12", 13, 1'b1, 3, 0, 0, 1'b0, 8, 1'b0);
    run_case("R12", 15, 1'b0, 0, 1, 0, 1'b1, 4, 1'b1);
    done = 1;
    report();
  end

endmodule